// File: doc/BRIEF.md
# Shared Interrupt Line Router with Sticky Status

This block gathers interrupt requests from the on-board sources of a small control device and folds them onto eight legacy interrupt lines. There are five source groups: a three-channel timer, a digital I/O bank, eight auxiliary GPIOs, a watchdog and a thermal group. The thermal group has four events: alert, thermal trip, generic event and battery low. Each individual source has an arm bit and a sticky pending bit. Each group has an enable bit and a 3-bit line select. Any number of groups may share a line, and the line is then the OR of everything routed onto it. The eight line outputs are high-true and feed a serial interrupt frame generator that lives outside this block.

Eleven ISA bus interrupts bypass the pending logic. Each has its own enable and is forwarded combinationally. Software reaches every control and status field through a single 8-bit register port with a 4-bit address. Reads are combinational and have no side effects. Writes take effect on the clock edge.

Top module: `irq_route_unit`

## Requirements
- R1: A group's 3-bit select value k (0..7) drives `line_irq[k]`. The bit index k stands for IRQ3, IRQ4, IRQ5, IRQ6, IRQ7, IRQ9, IRQ10 and IRQ11 respectively.
- R2: A group with its enable bit (bit 7 of its control register) at 0 drives no line, even when its sources are pending.
- R3: A pending bit sets when its request rises (it was low at the previous clock edge and is high now) while its arm bit is 1. A request that stays high sets the bit only once. A disarmed source never sets.
- R4: A write to a status address clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R5: When a new rising edge and a write-one clear hit the same bit in the same cycle, the bit stays set.
- R6: A line is high while any enabled group routed to it has a source that is both armed and pending. Clearing one of two groups that share a line leaves the line high.
- R7: Each of the three timer channels has its own arm bit (control address 0, bits 2:0) and its own pending bit (address 1, bits 2:0).
- R8: Each auxiliary GPIO bit has its own arm bit (address 5) and its own pending bit (address 6), with the bit index equal to the GPIO index.
- R9: The thermal group uses bit 0 for alert, bit 1 for trip, bit 2 for event and bit 3 for battery low. The arm bits are at address 9, bits 3:0, and the pending bits are at address 10, bits 3:0. Address 10 bit 7 reads the live battery-low request level.
- R10: `isa_irq_out[i] = isa_irq_in[i]` when enable bit i is set and 0 otherwise, with no clocked delay. The enables are address 11 (bits 7:0 for inputs 0..7) and address 12 (bits 2:0 for inputs 8..10). The input order is IRQ3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15, and all enables are 0 after reset.
- R11: Asserting `rst_n` low clears every control and pending bit, so every output reads 0.
- R12: The registers read back as follows. Addr 0 is the timer control (7 enable, 6:4 select, 2:0 arms); addr 2 is the digital I/O control (7, 6:4, 0 arm); addr 3 is the digital I/O pending bit 0; addr 4 is the GPIO control (7, 6:4); addr 7 is the watchdog control (7, 6:4, 0 arm); addr 8 is the watchdog pending bit 0; addr 9 is the thermal control (7, 6:4, 3:0 arms). Unused bits and addresses 13 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low platform reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| tmr_req | input | 3 | Timer channel requests |
| dio_req | input | 1 | Digital I/O bank request |
| gpio_req | input | 8 | Auxiliary GPIO requests |
| wdt_req | input | 1 | Watchdog request |
| thm_req | input | 4 | Thermal requests (alert, trip, event, battery low) |
| isa_irq_in | input | 11 | ISA bus interrupt inputs |
| line_irq | output | 8 | Routed high-true legacy interrupt lines |
| isa_irq_out | output | 11 | Gated ISA interrupt outputs |

## Verification
The hardest case to reach is a rising request edge that lands in exactly the same clock as a write-one clear of the same bit. The bench reaches it by raising the request and presenting the clear write on the same falling edge, so both are seen by one rising edge. A second hard case is a line shared by two groups, where one group is cleared while the other is still pending. The bench builds it by pointing the watchdog and thermal groups at the same select and releasing their pending bits one at a time. A behavioural model of the pending bits and routing runs alongside and is compared with the outputs every cycle.

// File: rtl/irq_route_unit.sv
module irq_route_unit #(
  parameter int NSRC = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [2:0]  tmr_req,
  input  logic        dio_req,
  input  logic [7:0]  gpio_req,
  input  logic        wdt_req,
  input  logic [3:0]  thm_req,
  input  logic [10:0] isa_irq_in,
  output logic [7:0]  line_irq,
  output logic [10:0] isa_irq_out
);

  logic [7:0] tmr_ctl, dio_ctl, gpio_ctl, gpio_arm, wdt_ctl, thm_ctl, isa_lo;
  logic [2:0] isa_hi;
  logic [NSRC-1:0] st, prev, req, arm, set_v, clr, pend;

  assign req   = {thm_req, wdt_req, gpio_req, dio_req, tmr_req};
  assign arm   = {thm_ctl[3:0], wdt_ctl[0], gpio_arm, dio_ctl[0], tmr_ctl[2:0]};
  assign set_v = req & ~prev & arm;
  assign pend  = st & arm;

  assign clr = wr_en ? {(addr == 4'd10) ? wdata[3:0] : 4'h0,
                        (addr == 4'd8)  ? wdata[0]   : 1'b0,
                        (addr == 4'd6)  ? wdata      : 8'h00,
                        (addr == 4'd3)  ? wdata[0]   : 1'b0,
                        (addr == 4'd1)  ? wdata[2:0] : 3'h0} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      prev <= '0;
    end else begin
      st   <= (st & ~clr) | set_v;
      prev <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_ctl <= '0; dio_ctl <= '0; gpio_ctl <= '0; gpio_arm <= '0;
      wdt_ctl <= '0; thm_ctl <= '0; isa_lo <= '0; isa_hi <= '0;
    end else if (wr_en) begin
      case (addr)
        4'd0:  tmr_ctl  <= wdata & 8'hF7;
        4'd2:  dio_ctl  <= wdata & 8'hF1;
        4'd4:  gpio_ctl <= wdata & 8'hF0;
        4'd5:  gpio_arm <= wdata;
        4'd7:  wdt_ctl  <= wdata & 8'hF1;
        4'd9:  thm_ctl  <= wdata;
        4'd11: isa_lo   <= wdata;
        4'd12: isa_hi   <= wdata[2:0];
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] route(input logic hit, input logic [7:0] ctl);
    return (hit && ctl[7]) ? (8'd1 << ctl[6:4]) : 8'd0;
  endfunction

  assign line_irq = route(|pend[2:0],   tmr_ctl)  |
                    route(pend[3],      dio_ctl)  |
                    route(|pend[11:4],  gpio_ctl) |
                    route(pend[12],     wdt_ctl)  |
                    route(|pend[16:13], thm_ctl);

  assign isa_irq_out = isa_irq_in & {isa_hi, isa_lo};

  always_comb begin
    case (addr)
      4'd0:    rdata = tmr_ctl;
      4'd1:    rdata = {5'd0, st[2:0]};
      4'd2:    rdata = dio_ctl;
      4'd3:    rdata = {7'd0, st[3]};
      4'd4:    rdata = gpio_ctl;
      4'd5:    rdata = gpio_arm;
      4'd6:    rdata = st[11:4];
      4'd7:    rdata = wdt_ctl;
      4'd8:    rdata = {7'd0, st[12]};
      4'd9:    rdata = thm_ctl;
      4'd10:   rdata = {thm_req[3], 3'd0, st[16:13]};
      4'd11:   rdata = isa_lo;
      4'd12:   rdata = {5'd0, isa_hi};
      default: rdata = 8'd0;
    endcase
  end

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((st & $past(st)) == $past(st)));

  assert_disarmed_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((st & ~$past(st)) & ~$past(arm)) == '0));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((st & $past(clr) & ~$past(set_v)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((st & $past(set_v)) == $past(set_v)));

  assert_groups_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_ctl[7] | dio_ctl[7] | gpio_ctl[7] | wdt_ctl[7] | thm_ctl[7]) |-> (line_irq == 8'd0));

  assert_isa_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_lo == 8'd0 && isa_hi == 3'd0) |-> (isa_irq_out == 11'd0));

endmodule

// File: tb/irq_route_unit_test.sv
module irq_route_unit_test;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] tmr_req = 0;
  logic dio_req = 0, wdt_req = 0;
  logic [7:0] gpio_req = 0;
  logic [3:0] thm_req = 0;
  logic [10:0] isa_irq_in = 0, isa_irq_out;
  logic [7:0] line_irq;

  int checks = 0, fails = 0;

  irq_route_unit uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tmr_req(tmr_req), .dio_req(dio_req), .gpio_req(gpio_req),
    .wdt_req(wdt_req), .thm_req(thm_req), .isa_irq_in(isa_irq_in),
    .line_irq(line_irq), .isa_irq_out(isa_irq_out));

  always #(PER/2) clk = ~clk;

  // behavioural reference
  logic [7:0] mreg [16];
  bit mst [17];
  bit mprev [17];

  function automatic bit mreq(int i);
    if (i < 3) return tmr_req[i];
    if (i == 3) return dio_req;
    if (i < 12) return gpio_req[i-4];
    if (i == 12) return wdt_req;
    return thm_req[i-13];
  endfunction

  function automatic bit marm(int i);
    if (i < 3) return mreg[0][i];
    if (i == 3) return mreg[2][0];
    if (i < 12) return mreg[5][i-4];
    if (i == 12) return mreg[7][0];
    return mreg[9][i-13];
  endfunction

  function automatic int mgrp_reg(int i);
    if (i < 3) return 0;
    if (i == 3) return 2;
    if (i < 12) return 4;
    if (i == 12) return 7;
    return 9;
  endfunction

  function automatic int stat_addr(int i);
    if (i < 3) return 1;
    if (i == 3) return 3;
    if (i < 12) return 6;
    if (i == 12) return 8;
    return 10;
  endfunction

  function automatic int stat_bit(int i);
    if (i < 3) return i;
    if (i == 3 || i == 12) return 0;
    if (i < 12) return i - 4;
    return i - 13;
  endfunction

  function automatic logic [7:0] wmask(int a);
    case (a)
      0: return 8'hF7; 2: return 8'hF1; 4: return 8'hF0; 5: return 8'hFF;
      7: return 8'hF1; 9: return 8'hFF; 11: return 8'hFF; 12: return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_line();
    logic [7:0] l = 0;
    for (int i = 0; i < 17; i++) begin
      logic [7:0] c = mreg[mgrp_reg(i)];
      if (mst[i] && marm(i) && c[7]) l[c[6:4]] = 1'b1;
    end
    return l;
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    logic [7:0] v = 0;
    if (a == 1 || a == 3 || a == 6 || a == 8 || a == 10) begin
      for (int i = 0; i < 17; i++) if (stat_addr(i) == a && mst[i]) v[stat_bit(i)] = 1'b1;
      if (a == 10) v[7] = thm_req[3];
      return v;
    end
    return mreg[a];
  endfunction

  initial for (int a = 0; a < 16; a++) mreg[a] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 16; a++) mreg[a] = 0;
      for (int i = 0; i < 17; i++) begin mst[i] = 0; mprev[i] = 0; end
    end else begin
      bit setb [17];
      for (int i = 0; i < 17; i++) setb[i] = mreq(i) && !mprev[i] && marm(i);
      if (wr_en) begin
        for (int i = 0; i < 17; i++)
          if (stat_addr(i) == int'(addr) && wdata[stat_bit(i)]) mst[i] = 0;
        if (wmask(int'(addr)) != 0) mreg[addr] = wdata & wmask(int'(addr));
      end
      for (int i = 0; i < 17; i++) begin
        if (setb[i]) mst[i] = 1;
        mprev[i] = mreq(i);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1 R2 R6 line_irq", 16'(line_irq), 16'(exp_line()));
      chk("R10 isa_irq_out", 16'(isa_irq_out), 16'(isa_irq_in & {mreg[12][2:0], mreg[11]}));
      chk("R12 rdata", 16'(rdata), 16'(exp_rd(int'(addr))));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; cyc(); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    addr = a; #1; chk(tag, 16'(rdata), 16'(exp));
  endtask

  initial begin
    #(PER * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rd(4'd0, 8'h00, "R11 reset ctl");
    chk("R11 reset line", 16'(line_irq), 16'h0);
    chk("R11 reset isa", 16'(isa_irq_out), 16'h0);
    rst_n = 1; cyc();

    wr(4'd0, 8'hFF); rd(4'd0, 8'hF7, "R12 tmr ctl readback");
    wr(4'd15, 8'hFF); rd(4'd15, 8'h00, "R12 unused addr");

    // timer channel 1
    wr(4'd0, 8'h87);
    tmr_req[1] = 1; cyc(); tmr_req[1] = 0; cyc();
    rd(4'd1, 8'h02, "R7 timer ch1 pending");
    chk("R1 sel0 -> IRQ3 bit", 16'(line_irq), 16'h01);
    wr(4'd1, 8'h05); rd(4'd1, 8'h02, "R4 zero bits keep");
    wr(4'd1, 8'h02); rd(4'd1, 8'h00, "R4 write one clears");
    chk("R4 line drops", 16'(line_irq), 16'h00);

    // held request sets once
    tmr_req[0] = 1; cyc(2);
    rd(4'd1, 8'h01, "R3 edge sets");
    wr(4'd1, 8'h01); cyc(2);
    rd(4'd1, 8'h00, "R3 held level no reset");
    tmr_req[0] = 0; cyc();

    // disarmed channel 2
    wr(4'd0, 8'h83);
    tmr_req[2] = 1; cyc(); tmr_req[2] = 0; cyc();
    rd(4'd1, 8'h00, "R3 disarmed no set");
    wr(4'd0, 8'h00);

    // GPIO select sweep
    wr(4'd5, 8'hFF);
    gpio_req[5] = 1; cyc(); gpio_req[5] = 0; cyc();
    rd(4'd6, 8'h20, "R8 gpio5 pending");
    for (int s = 0; s < 8; s++) begin
      wr(4'd4, 8'h80 | 8'(s << 4));
      chk("R1 select mapping", 16'(line_irq), 16'(8'd1 << s));
    end
    wr(4'd4, 8'h20);
    chk("R2 group disabled", 16'(line_irq), 16'h00);
    wr(4'd5, 8'h0F);
    gpio_req = 8'hA5; cyc(); gpio_req = 0; cyc();
    rd(4'd6, 8'h25, "R8 per-bit arm");
    wr(4'd6, 8'hFF); rd(4'd6, 8'h00, "R8 clear all");

    // shared line
    wr(4'd7, 8'hB1); wr(4'd9, 8'hBF);
    wdt_req = 1; thm_req[1] = 1; cyc(); wdt_req = 0; thm_req[1] = 0; cyc();
    chk("R6 shared line", 16'(line_irq), 16'h08);
    wr(4'd8, 8'h01);
    chk("R6 other group holds line", 16'(line_irq), 16'h08);
    rd(4'd10, 8'h02, "R9 trip bit");
    wr(4'd10, 8'h02);
    chk("R6 line released", 16'(line_irq), 16'h00);

    // set wins over clear
    thm_req[0] = 1; cyc(); thm_req[0] = 0; cyc();
    rd(4'd10, 8'h01, "R9 alert bit");
    thm_req[0] = 1; addr = 4'd10; wdata = 8'h01; wr_en = 1; cyc(); wr_en = 0; thm_req[0] = 0;
    cyc();
    rd(4'd10, 8'h01, "R5 set beats clear");
    wr(4'd10, 8'h01);
    rd(4'd10, 8'h00, "R5 later clear works");

    // live battery-low level and event
    thm_req[3] = 1; cyc(2);
    rd(4'd10, 8'h88, "R9 battlow live and pending");
    thm_req[3] = 0; cyc();
    rd(4'd10, 8'h08, "R9 live bit follows input");
    thm_req[2] = 1; cyc(); thm_req[2] = 0; cyc();
    wr(4'd10, 8'h08);
    rd(4'd10, 8'h04, "R9 event bit");

    // ISA pass-through
    isa_irq_in = 11'h7FF; #1;
    chk("R10 disabled", 16'(isa_irq_out), 16'h000);
    wr(4'd11, 8'h05); wr(4'd12, 8'h04); #1;
    chk("R10 enabled", 16'(isa_irq_out), 16'h405);
    isa_irq_in = 11'h400; #1;
    chk("R10 combinational", 16'(isa_irq_out), 16'h400);
    rd(4'd12, 8'h04, "R12 isa hi readback");

    // mid-run reset
    rst_n = 0; cyc(2);
    chk("R11 reset line", 16'(line_irq), 16'h00);
    chk("R11 reset isa", 16'(isa_irq_out), 16'h000);
    rd(4'd10, 8'h00, "R11 reset pending");
    rst_n = 1; cyc(2);
    rd(4'd9, 8'h00, "R11 ctl stays zero");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule